// File: doc/BRIEF.md
# Prescaled Programmable Period Counter

This block derives a repeating timing event from the system clock. A two-bit select picks a prescale factor for the counting clock. An eight-bit down-counter is then loaded from an active-low preset word and counts the cycle out. A load is not started when the count runs out. It is started by a transition on a trigger input, which the block first passes through a synchronizer. In normal use the output is wired back to the trigger, so the block runs freely. If the trigger is driven from elsewhere, each accepted transition produces exactly one timed cycle.

A three-bit mode word selects between two behaviours. In counting mode only rising trigger edges start a cycle, and the output gives a single-clock pulse when the cycle ends. In dividing mode both trigger edges start a cycle, and the output toggles when the cycle ends, which gives a square wave when the output is fed back. An all-zero preset value cannot be used. The block flags it and refuses to start a cycle while it is present.

Top module: `prescaled_period_timer`

## Requirements
- R1: While `rst_n` is low, and afterwards until a trigger transition arrives, `tick_out` is low and no cycle runs.
- R2: The preset value is N = ~`preset_n`, with bit 0 weighted 1 up to bit 7 weighted 128. With `div_sel` = 00 (prescaler bypassed), a cycle lasts N+1 clocks. `tick_out` changes on the (N+5)th rising clock edge, counting the first edge that samples the trigger change as edge 1.
- R3: `div_sel` 01, 10 and 11 select prescale factors P = 16, 256 and 4096. A cycle then lasts N*P clocks, and `tick_out` changes on edge N*P+4 counted as in R2.
- R4: Counting mode is `mode_sel` = 001. Only a rising trigger edge starts a cycle, and a falling edge has no effect. At the end of a cycle `tick_out` is high for exactly one clock.
- R5: Dividing mode is `mode_sel` = 010. A rising or a falling trigger edge starts a cycle, and `tick_out` inverts at the end of the cycle.
- R6: Without feedback, one accepted trigger transition produces exactly one cycle end, after which the block stays idle.
- R7: A trigger edge accepted while a cycle is running restarts the count from the preset value, and the earlier cycle produces no output event.
- R8: When `preset_n` is all ones (N = 0), `cfg_err` is high, and trigger edges start no cycle.
- R9: Any other `mode_sel` value forces `tick_out` low from the next clock edge and starts no cycle.
- R10: With `tick_out` fed back to `trig_in` and the prescaler bypassed, counting mode pulses every N+5 clocks, and dividing mode toggles every N+5 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous trigger; edges start a cycle |
| preset_n | input | 8 | Active-low cycle length N |
| div_sel | input | 2 | Prescale select: 00=1, 01=16, 10=256, 11=4096 |
| mode_sel | input | 3 | 001 counting, 010 dividing, other values idle |
| tick_out | output | 1 | Pulse (counting) or toggle (dividing) output |
| cfg_err | output | 1 | High while the preset value is zero |

## Verification
Most internal faults show up as a wrong number of clocks between a trigger edge and the output event. An off-by-one in the counter's end test moves the event by one clock when the prescaler is bypassed, and by a full prescale period when it is active. Each scenario therefore measures that latency to the exact edge. Faults in edge selection, such as a falling edge that reloads in counting mode or a retrigger that fails to restart the count, appear as a missing or extra output event within one cycle length. A wrong prescale mask is visible after a single cycle, at most 4100 clocks.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned STEP   = 4;
  localparam int unsigned PRE_W  = STEP * ((1 << SEL_W) - 1);
  localparam int unsigned MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_COUNT  = 3'b001;
  localparam logic [MODE_W-1:0] MODE_DIVIDE = 3'b010;
endpackage

// File: rtl/ppt_in_sync.sv
module ppt_in_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, stab_q, hist_q;
  logic rise_q, fall_q;
  logic rise_d, fall_d;

  always_comb begin
    rise_d = stab_q & ~hist_q;
    fall_d = ~stab_q & hist_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
      hist_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
      hist_q <= stab_q;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/ppt_prescaler.sv
module ppt_prescaler #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned STEP  = 4,
  localparam int unsigned PRE_W = STEP * ((1 << SEL_W) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             bypass,
  output logic             tick
);
  localparam logic [PRE_W-1:0] ONES = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] wrap_mask;
  logic             tick_c;

  always_comb begin
    wrap_mask = ~(ONES << (STEP * sel));
    tick_c    = run && ((sel == '0) || (pre_q == wrap_mask));
    if (clr || !run || tick_c) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  assign bypass = (sel == '0);
  assign tick   = tick_c;
endmodule

// File: rtl/ppt_down_counter.sv
module ppt_down_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] preset,
  input  logic             halt,
  input  logic             tick,
  input  logic             bypass,
  output logic             active,
  output logic [CNT_W-1:0] value,
  output logic             expire
);
  localparam logic [CNT_W-1:0] LAST_PRE = CNT_W'(1);

  logic [CNT_W-1:0] val_q, val_d;
  logic             act_q, act_d;
  logic             at_end;
  logic             expire_c;

  always_comb begin
    at_end   = bypass ? (val_q == '0) : (val_q == LAST_PRE);
    expire_c = act_q && tick && at_end && !load && !halt;
    val_d    = val_q;
    act_d    = act_q;
    if (halt) begin
      act_d = 1'b0;
    end else if (load) begin
      val_d = preset;
      act_d = 1'b1;
    end else if (act_q && tick) begin
      if (at_end) begin
        act_d = 1'b0;
      end else begin
        val_d = val_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      act_q <= 1'b0;
    end else begin
      val_q <= val_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;
  assign value  = val_q;
  assign expire = expire_c;
endmodule

// File: rtl/prescaled_period_timer.sv
module prescaled_period_timer
  import ppt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic [CNT_W-1:0]  preset_n,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic [MODE_W-1:0] mode_sel,
  output logic              tick_out,
  output logic              cfg_err
);
  logic             rise, fall;
  logic             is_count, is_divide, mode_ok;
  logic             zero_preset;
  logic [CNT_W-1:0] preset_val;
  logic             load;
  logic             pre_tick, bypass;
  logic             cnt_active, expire;
  logic [CNT_W-1:0] cnt_value;
  logic             out_q, out_d;

  ppt_in_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(trig_in),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  always_comb begin
    preset_val  = ~preset_n;
    zero_preset = (preset_val == '0);
    is_count    = (mode_sel == MODE_COUNT);
    is_divide   = (mode_sel == MODE_DIVIDE);
    mode_ok     = is_count || is_divide;
    load        = mode_ok && !zero_preset && (rise || (is_divide && fall));
  end

  ppt_prescaler #(
    .SEL_W(SEL_W),
    .STEP (STEP)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load),
    .run   (cnt_active),
    .sel   (div_sel),
    .bypass(bypass),
    .tick  (pre_tick)
  );

  ppt_down_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .preset(preset_val),
    .halt  (!mode_ok),
    .tick  (pre_tick),
    .bypass(bypass),
    .active(cnt_active),
    .value (cnt_value),
    .expire(expire)
  );

  always_comb begin
    if (is_count) begin
      out_d = expire;
    end else if (is_divide) begin
      out_d = out_q ^ expire;
    end else begin
      out_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else begin
      out_q <= out_d;
    end
  end

  assign tick_out = out_q;
  assign cfg_err  = zero_preset;
endmodule

// File: rtl/ppt_checker.sv
module ppt_checker
  import ppt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_sel,
  input logic              tick_out,
  input logic              cfg_err,
  input logic              cnt_active,
  input logic [CNT_W-1:0]  cnt_value,
  input logic              load,
  input logic              expire
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_COUNT && tick_out) |=> (!tick_out || mode_sel != MODE_COUNT)); // R4

  AST_DIV_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_DIVIDE && expire) |=> (tick_out != $past(tick_out))); // R5

  AST_BADMODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != MODE_COUNT && mode_sel != MODE_DIVIDE) |=> !tick_out); // R9

  AST_ZERO_NOSTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !cnt_active) |=> !cnt_active); // R8

  AST_COUNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_active && !load) |=> (cnt_value <= $past(cnt_value))); // R2
endmodule

bind prescaled_period_timer ppt_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .tick_out  (tick_out),
  .cfg_err   (cfg_err),
  .cnt_active(cnt_active),
  .cnt_value (cnt_value),
  .load      (load),
  .expire    (expire)
);

// File: tb/tb_prescaled_period_timer.sv
`timescale 1ns/1ps
module tb_prescaled_period_timer;
  logic       clk;
  logic       rst_n;
  logic       trig_drv;
  logic       kick;
  logic       fb_en;
  logic [7:0] preset_n;
  logic [1:0] div_sel;
  logic [2:0] mode_sel;
  logic       tick_out;
  logic       cfg_err;
  logic       trig;

  int n_chk;
  int n_err;

  assign trig = fb_en ? ((tick_out & fb_en) ^ kick) : trig_drv;

  prescaled_period_timer dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig),
    .preset_n(preset_n),
    .div_sel (div_sel),
    .mode_sel(mode_sel),
    .tick_out(tick_out),
    .cfg_err (cfg_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts rising edges until tick_out changes; 0 if it never does
  task automatic wait_change(input int limit, output int n);
    logic start;
    start = tick_out;
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk);
      #1;
      if (tick_out != start) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic flip_trig();
    @(negedge clk);
    trig_drv = ~trig_drv;
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0;
    trig_drv = 1'b0; kick = 1'b0; fb_en = 1'b0;
    preset_n = ~8'd5; div_sel = 2'b00; mode_sel = 3'b001;
    repeat (3) @(posedge clk);
    #1;
    check(tick_out == 1'b0, "R1 out in reset", tick_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_change(50, n);
    check(n == 0, "R1 idle after reset", n, 0);
  endtask

  task automatic t_count_oneshot();
    int n;
    preset_n = ~8'd5; div_sel = 2'b00; mode_sel = 3'b001;
    flip_trig();
    wait_change(40, n);
    check(n == 10, "R2 bypass latency", n, 10);
    check(tick_out == 1'b1, "R4 pulse high", tick_out, 1);
    @(posedge clk); #1;
    check(tick_out == 1'b0, "R4 pulse one clock", tick_out, 0);
    wait_change(40, n);
    check(n == 0, "R6 single cycle only", n, 0);
    flip_trig();
    wait_change(40, n);
    check(n == 0, "R4 falling edge ignored", n, 0);
  endtask

  task automatic t_prescale();
    int n;
    int exp;
    mode_sel = 3'b001;
    for (int s = 1; s <= 3; s++) begin
      div_sel = 2'(s);
      preset_n = ~8'(4 - s);
      exp = (4 - s) * (1 << (4 * s)) + 4;
      flip_trig();
      wait_change(exp + 20, n);
      check(n == exp, "R3 prescaled latency", n, exp);
      @(posedge clk); #1;
      check(tick_out == 1'b0, "R3 pulse ends", tick_out, 0);
      flip_trig();
      repeat (10) @(posedge clk);
    end
  endtask

  task automatic t_divider();
    int n;
    div_sel = 2'b00; preset_n = ~8'd7; mode_sel = 3'b010;
    flip_trig();
    wait_change(40, n);
    check(n == 12, "R5 toggle on rising trigger", n, 12);
    check(tick_out == 1'b1, "R5 toggled high", tick_out, 1);
    flip_trig();
    wait_change(40, n);
    check(n == 12, "R5 falling trigger also starts", n, 12);
    check(tick_out == 1'b0, "R5 toggled low", tick_out, 0);
    wait_change(40, n);
    check(n == 0, "R6 divider stops", n, 0);
  endtask

  task automatic t_retrigger();
    int n;
    preset_n = ~8'd10; mode_sel = 3'b010; div_sel = 2'b00;
    flip_trig();
    repeat (6) @(posedge clk);
    #1;
    check(tick_out == 1'b0, "R7 no early event", tick_out, 0);
    flip_trig();
    wait_change(40, n);
    check(n == 15, "R7 restart latency", n, 15);
    wait_change(30, n);
    check(n == 0, "R7 first cycle dropped", n, 0);
  endtask

  task automatic t_zero();
    int n;
    preset_n = 8'hFF;
    #1;
    check(cfg_err == 1'b1, "R8 flag zero preset", cfg_err, 1);
    flip_trig();
    wait_change(60, n);
    check(n == 0, "R8 no cycle started", n, 0);
    preset_n = ~8'd3;
    #1;
    check(cfg_err == 1'b0, "R8 flag clears", cfg_err, 0);
  endtask

  task automatic t_badmode();
    int n;
    @(negedge clk);
    mode_sel = 3'b111;
    @(posedge clk); #1;
    check(tick_out == 1'b0, "R9 output forced low", tick_out, 0);
    flip_trig();
    wait_change(60, n);
    check(n == 0, "R9 trigger ignored", n, 0);
  endtask

  task automatic t_feedback();
    int n1, n2, n;
    @(negedge clk);
    mode_sel = 3'b001; div_sel = 2'b00; preset_n = ~8'd4;
    trig_drv = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    fb_en = 1'b1; kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    wait_change(40, n);
    check(n != 0, "R10 counting loop starts", n, 1);
    for (int k = 0; k < 2; k++) begin
      wait_change(40, n1);
      wait_change(40, n2);
      check(n1 + n2 == 9, "R10 counting period", n1 + n2, 9);
    end
    wait_change(40, n);
    @(negedge clk);
    fb_en = 1'b0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    mode_sel = 3'b010; preset_n = ~8'd6;
    repeat (5) @(posedge clk);
    @(negedge clk);
    fb_en = 1'b1; kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    wait_change(40, n);
    check(n != 0, "R10 divider loop starts", n, 1);
    for (int k = 0; k < 2; k++) begin
      wait_change(40, n1);
      check(n1 == 11, "R10 divider half period", n1, 11);
    end
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    t_reset();
    t_count_oneshot();
    t_prescale();
    t_divider();
    t_retrigger();
    t_zero();
    t_badmode();
    t_feedback();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule